// File: doc/BRIEF.md
# Eight-Line GPIO Port with Pin Interrupt Detection

This block is a register-mapped port of eight general-purpose pins. A processor reaches it over a plain byte-wide register bus. Each transfer has an address, a write strobe, write data and combinational read data. Each pin is an input or an output, set by a direction bit. Output values sit in a data register. That register is read and written through an address window: a per-pin lane mask is carried in the word address, so one access can touch any subset of pins without a read-modify-write.

Every pin input passes through a two-flop synchronizer. It then feeds an interrupt detector that senses either a level or an edge. Edge sensing can be single- or dual-edge, and a polarity bit picks high/rising versus low/falling. Latched edges stay pending until software writes a one to the matching clear bit. Level status tracks the pin. The raw status is qualified by an enable mask, and the qualified bits are ORed into a single interrupt line. The pads appear as separate input, output and output-enable vectors.

Top module: `gpio8_irq`

## Requirements
- R1: After reset every register reads 0, and `pin_oe`, `pin_out` and `irq_out` are 0.
- R2: A write at a word-aligned address with bits [11:10] = 00 updates only the data bits whose lane-mask bit (address bit 2+i for pin i) is 1. The other data bits keep their value.
- R3: A read in the data window returns 0 for every pin whose lane-mask bit is 0. For an unmasked pin it returns the stored data bit when the pin is an output, and the synchronized pin input when it is an input.
- R4: Direction register (0x400): bit value 1 makes the pin an output. `pin_oe` equals the direction register from the clock edge after the write.
- R5: The data register is written whatever the direction, and `pin_out` always shows it. A value stored while a pin is an input therefore reaches the pad as soon as that pin's direction bit becomes 1.
- R6: With its sense bit (0x404) at 1, a pin's raw status (0x414) is 1 while the synchronized input equals its polarity bit (0x40C). Writing the clear register does not remove that status while the level persists.
- R7: With sense 0 and both-edges (0x408) at 0, a pin latches raw status on a rising edge when polarity is 1 and on a falling edge when polarity is 0. An edge of the other direction latches nothing.
- R8: With sense 0 and both-edges at 1, rising and falling edges both latch status, whatever the polarity bit holds.
- R9: Writing 1 to bit i of the clear register (0x41C) removes pin i's latched edge status. Writing 0 leaves it unchanged. The clear register reads 0.
- R10: The masked status (0x418) is the raw status ANDed with the enable register (0x410). `irq_out` is 1 exactly when any masked status bit is 1.
- R11: A pin change set up before clock edge k becomes visible in a data read after edge k+1. A resulting edge status appears after edge k+2.
- R12: Raw and masked status are read-only: writes to 0x414 and 0x418 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_we | input | 1 | Write strobe for the current address |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench aims at lane-mask handling in the data window. A design that ignores the mask would corrupt neighbouring pins on writes or leak their values on reads. It tries every combination of sense, both-edges and polarity against random pin transitions. This catches a detector that fires on the wrong edge, or one that lets the polarity bit override dual-edge mode. Directed cases count the synchronizer latency cycle by cycle. They show that a level interrupt survives a clear while the level persists, that writing zeros to the clear register or writes to the status registers leave the status untouched, and that a value written to an input pin reaches the pad once its direction is switched to output.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;

  localparam int PIN_W = 8;

  // Word index of the control registers (address bits [4:2] above 0x400)
  typedef enum logic [2:0] {
    IDX_DIR   = 3'd0,
    IDX_SENSE = 3'd1,
    IDX_BOTH  = 3'd2,
    IDX_POL   = 3'd3,
    IDX_IE    = 3'd4,
    IDX_RIS   = 3'd5,
    IDX_MIS   = 3'd6,
    IDX_CLR   = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [PIN_W-1:0] dir;
    logic [PIN_W-1:0] sense;
    logic [PIN_W-1:0] both;
    logic [PIN_W-1:0] pol;
    logic [PIN_W-1:0] ie;
  } pin_cfg_t;

endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
  parameter int NPIN   = 8,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] async_in,
  output logic [NPIN-1:0] sync_out,
  output logic [NPIN-1:0] prev_out
);

  logic [NPIN-1:0] stage_q [STAGES];
  logic [NPIN-1:0] stage_d [STAGES];
  logic [NPIN-1:0] prev_q;
  logic [NPIN-1:0] prev_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = async_in;
    end else begin : g_next
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign prev_d = stage_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign sync_out = stage_q[STAGES-1];
  assign prev_out = prev_q;

endmodule

// File: rtl/gpio8_detect.sv
module gpio8_detect
  import gpio8_pkg::*;
#(
  parameter int NPIN = PIN_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pin_cfg_t        cfg,
  input  logic [NPIN-1:0] sync_in,
  input  logic [NPIN-1:0] prev_in,
  input  logic [NPIN-1:0] clr_v,
  output logic [NPIN-1:0] evt_vec,
  output logic [NPIN-1:0] edge_q,
  output logic [NPIN-1:0] raw_st
);

  logic [NPIN-1:0] edge_d;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise;
    logic fall;
    logic hit;

    assign rise = sync_in[i] & ~prev_in[i];
    assign fall = ~sync_in[i] & prev_in[i];

    always_comb begin
      if (cfg.both[i]) begin
        hit = rise | fall;
      end else if (cfg.pol[i]) begin
        hit = rise;
      end else begin
        hit = fall;
      end
    end

    // Edge events count only on edge-sensed pins; a new event wins over a clear
    assign evt_vec[i] = ~cfg.sense[i] & hit;
    assign edge_d[i]  = evt_vec[i] | (edge_q[i] & ~clr_v[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        edge_q[i] <= 1'b0;
      end else begin
        edge_q[i] <= edge_d[i];
      end
    end

    assign raw_st[i] = cfg.sense[i] ? ~(sync_in[i] ^ cfg.pol[i]) : edge_q[i];
  end

endmodule

// File: rtl/gpio8_regs.sv
module gpio8_regs
  import gpio8_pkg::*;
#(
  parameter int NPIN   = PIN_W,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  input  logic [NPIN-1:0]   sync_in,
  input  logic [NPIN-1:0]   raw_st,
  output pin_cfg_t          cfg,
  output logic [NPIN-1:0]   dout_q,
  output logic [NPIN-1:0]   clr_v,
  output logic [NPIN-1:0]   bus_rdata
);

  localparam int MASK_LO = 2;
  localparam int MASK_HI = MASK_LO + NPIN - 1;
  localparam int PAGE_LO = MASK_HI + 1;

  logic              aligned;
  logic              win_hit;
  logic              reg_hit;
  logic [NPIN-1:0]   lane_mask;
  reg_idx_e          idx;
  logic [NPIN-1:0]   dout_d;
  logic              dout_en;
  pin_cfg_t          cfg_d;
  logic              cfg_en;
  logic [NPIN-1:0]   mis;
  logic [NPIN-1:0]   pin_view;

  assign aligned   = (bus_addr[1:0] == 2'b00);
  assign lane_mask = bus_addr[MASK_HI:MASK_LO];
  assign idx       = reg_idx_e'(bus_addr[4:2]);
  assign win_hit   = aligned && (bus_addr[ADDR_W-1:PAGE_LO] == '0);
  assign reg_hit   = aligned
                   && (bus_addr[ADDR_W-1:PAGE_LO] == (ADDR_W-PAGE_LO)'(1))
                   && (bus_addr[MASK_HI:5] == '0);

  // Data register: lane-masked update
  always_comb begin
    dout_en = bus_we && win_hit;
    dout_d  = (dout_q & ~lane_mask) | (bus_wdata & lane_mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
    end else if (dout_en) begin
      dout_q <= dout_d;
    end
  end

  // Control registers
  always_comb begin
    cfg_d  = cfg;
    cfg_en = bus_we && reg_hit;
    unique case (idx)
      IDX_DIR:   cfg_d.dir   = bus_wdata;
      IDX_SENSE: cfg_d.sense = bus_wdata;
      IDX_BOTH:  cfg_d.both  = bus_wdata;
      IDX_POL:   cfg_d.pol   = bus_wdata;
      IDX_IE:    cfg_d.ie    = bus_wdata;
      default:   cfg_en      = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_en) begin
      cfg <= cfg_d;
    end
  end

  // Write-one-to-clear pulses
  assign clr_v = (bus_we && reg_hit && idx == IDX_CLR) ? bus_wdata : '0;

  assign mis      = raw_st & cfg.ie;
  assign pin_view = (cfg.dir & dout_q) | (~cfg.dir & sync_in);

  always_comb begin
    bus_rdata = '0;
    if (win_hit) begin
      bus_rdata = pin_view & lane_mask;
    end else if (reg_hit) begin
      unique case (idx)
        IDX_DIR:   bus_rdata = cfg.dir;
        IDX_SENSE: bus_rdata = cfg.sense;
        IDX_BOTH:  bus_rdata = cfg.both;
        IDX_POL:   bus_rdata = cfg.pol;
        IDX_IE:    bus_rdata = cfg.ie;
        IDX_RIS:   bus_rdata = raw_st;
        IDX_MIS:   bus_rdata = mis;
        default:   bus_rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio8_irq.sv
module gpio8_irq
  import gpio8_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PIN_W-1:0]  bus_wdata,
  output logic [PIN_W-1:0]  bus_rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              irq_out
);

  logic             rst_meta_q;
  logic             rst_sync_n;
  logic [PIN_W-1:0] sync_v;
  logic [PIN_W-1:0] prev_v;
  logic [PIN_W-1:0] clr_v;
  logic [PIN_W-1:0] evt_vec;
  logic [PIN_W-1:0] edge_q;
  logic [PIN_W-1:0] raw_st;
  logic [PIN_W-1:0] dout_q;
  logic [PIN_W-1:0] ie_q;
  pin_cfg_t         cfg;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gpio8_sync #(.NPIN(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pin_in),
    .sync_out (sync_v),
    .prev_out (prev_v)
  );

  gpio8_detect #(.NPIN(PIN_W)) u_detect (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cfg     (cfg),
    .sync_in (sync_v),
    .prev_in (prev_v),
    .clr_v   (clr_v),
    .evt_vec (evt_vec),
    .edge_q  (edge_q),
    .raw_st  (raw_st)
  );

  gpio8_regs #(.NPIN(PIN_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sync_in   (sync_v),
    .raw_st    (raw_st),
    .cfg       (cfg),
    .dout_q    (dout_q),
    .clr_v     (clr_v),
    .bus_rdata (bus_rdata)
  );

  assign ie_q    = cfg.ie;
  assign pin_out = dout_q;
  assign pin_oe  = cfg.dir;
  assign irq_out = |(raw_st & ie_q);

endmodule

// File: rtl/gpio8_irq_chk.sv
module gpio8_irq_chk #(
  parameter int ADDR_W = 12,
  parameter int NPIN   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPIN-1:0]   bus_wdata,
  input logic [NPIN-1:0]   pin_oe,
  input logic              irq_out,
  input logic [NPIN-1:0]   dout_q,
  input logic [NPIN-1:0]   ie_q,
  input logic [NPIN-1:0]   edge_q,
  input logic [NPIN-1:0]   evt_vec
);

  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'('h400);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'('h41C);

  logic            wr_dir;
  logic            wr_clr;
  logic            wr_win;
  logic [NPIN-1:0] lane;

  assign wr_dir = bus_we && (bus_addr == A_DIR);
  assign wr_clr = bus_we && (bus_addr == A_CLR);
  assign wr_win = bus_we && (bus_addr[ADDR_W-1:NPIN+2] == '0) && (bus_addr[1:0] == 2'b00);
  assign lane   = bus_addr[NPIN+1:2];

  p_masked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_win |=> (((dout_q ^ $past(dout_q)) & ~$past(lane)) == '0));

  p_oe_follows_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> (pin_oe == $past(bus_wdata)));

  p_edge_needs_event_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((edge_q & ~$past(edge_q) & ~$past(evt_vec)) == '0));

  p_clear_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((edge_q & $past(bus_wdata & ~evt_vec)) == '0));

  p_irq_needs_enable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_q == '0) |-> !irq_out);

endmodule

bind gpio8_irq gpio8_irq_chk #(.ADDR_W(ADDR_W), .NPIN(gpio8_pkg::PIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .irq_out   (irq_out),
  .dout_q    (dout_q),
  .ie_q      (ie_q),
  .edge_q    (edge_q),
  .evt_vec   (evt_vec)
);

// File: tb/gpio8_irq_tb.sv
`timescale 1ns/1ps
module gpio8_irq_tb;

  localparam logic [11:0] A_WIN   = 12'h3FC;
  localparam logic [11:0] A_DIR   = 12'h400;
  localparam logic [11:0] A_SENSE = 12'h404;
  localparam logic [11:0] A_BOTH  = 12'h408;
  localparam logic [11:0] A_POL   = 12'h40C;
  localparam logic [11:0] A_IE    = 12'h410;
  localparam logic [11:0] A_RIS   = 12'h414;
  localparam logic [11:0] A_MIS   = 12'h418;
  localparam logic [11:0] A_CLR   = 12'h41C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic [7:0]  pin_oe;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio8_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  // Called at a negedge; consumes one clock
  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] exp_ris(input logic [7:0] o, input logic [7:0] n,
      input logic [7:0] sen, input logic [7:0] bo, input logic [7:0] po);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) begin
      if (sen[i])     r[i] = (n[i] == po[i]);
      else if (bo[i]) r[i] = (o[i] != n[i]);
      else if (po[i]) r[i] = !o[i] && n[i];
      else            r[i] = o[i] && !n[i];
    end
    return r;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] mdir, mdout, old, nw, sen, bo, po, ie, msk, e;
    void'($urandom(32'h0000_5EED));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(A_DIR, d);   chk("R1 dir", d, 8'h00);
    peek(A_WIN, d);   chk("R1 data", d, 8'h00);
    peek(A_RIS, d);   chk("R1 ris", d, 8'h00);
    chk("R1 pin_oe", pin_oe, 8'h00);
    chk("R1 pin_out", pin_out, 8'h00);
    chk("R1 irq", {7'd0, irq_out}, 8'h00);

    // R5 store while input, drive after direction set
    wr(A_WIN, 8'hA5);
    chk("R5 out while input", pin_out, 8'hA5);
    chk("R5 oe while input", pin_oe, 8'h00);
    wr(A_DIR, 8'hFF);
    chk("R4 oe after dir", pin_oe, 8'hFF);
    chk("R5 out after dir", pin_out, 8'hA5);
    // R2 masked write: only pins 1 and 6 (address bits 3 and 8)
    wr(12'h108, 8'h00);
    peek(A_WIN, d);   chk("R2 masked write", d, 8'hA5 & ~8'h42 | 8'h00 & 8'h42);
    wr(A_DIR, 8'h00);
    wr(A_WIN, 8'h00);

    // R11 latency: rising edge on pin 0, rising-sensed
    wr(A_POL, 8'h01);
    wr(A_IE, 8'h01);
    pin_in = 8'h01;
    peek(A_WIN, d);   chk("R11 before edge k", d, 8'h00);
    @(negedge clk);
    peek(A_WIN, d);   chk("R11 after k", d, 8'h00);
    @(negedge clk);
    peek(A_WIN, d);   chk("R11 after k+1 data", d, 8'h01);
    peek(A_RIS, d);   chk("R11 after k+1 ris", d, 8'h00);
    @(negedge clk);
    peek(A_RIS, d);   chk("R11 after k+2 ris", d, 8'h01);
    chk("R10 irq", {7'd0, irq_out}, 8'h01);

    // R9 zero write no effect, one clears
    wr(A_CLR, 8'h00);
    peek(A_RIS, d);   chk("R9 zero write", d, 8'h01);
    peek(A_CLR, d);   chk("R9 clr reads 0", d, 8'h00);
    // R12 status writes ignored
    wr(A_RIS, 8'h00);
    wr(A_MIS, 8'h00);
    peek(A_RIS, d);   chk("R12 ris write ignored", d, 8'h01);
    peek(A_MIS, d);   chk("R12 mis", d, 8'h01);
    wr(A_CLR, 8'h01);
    peek(A_RIS, d);   chk("R9 one clears", d, 8'h00);
    chk("R10 irq low", {7'd0, irq_out}, 8'h00);

    // R6 level high on pin 0 cannot be cleared
    wr(A_SENSE, 8'h01);
    peek(A_RIS, d);   chk("R6 level set", d, 8'h01);
    wr(A_CLR, 8'hFF);
    peek(A_RIS, d);   chk("R6 clear ignored", d, 8'h01);
    pin_in = 8'h00;
    repeat (2) @(negedge clk);
    peek(A_RIS, d);   chk("R6 level gone", d, 8'h00);
    wr(A_SENSE, 8'h00);
    wr(A_POL, 8'h00);
    wr(A_IE, 8'h00);
    wr(A_CLR, 8'hFF);

    // R2 R3 R4 random data-window traffic
    mdir = 8'h00; mdout = 8'h00;
    for (int it = 0; it < 40; it++) begin
      mdir = 8'($urandom);
      wr(A_DIR, mdir);
      chk("R4 oe random", pin_oe, mdir);
      msk = 8'($urandom);
      d = 8'($urandom);
      wr({2'b00, msk, 2'b00}, d);
      mdout = (mdout & ~msk) | (d & msk);
      chk("R2 random write", pin_out, mdout);
      pin_in = 8'($urandom);
      repeat (3) @(negedge clk);
      msk = 8'($urandom);
      peek({2'b00, msk, 2'b00}, d);
      chk("R3 random read", d, msk & ((mdir & mdout) | (~mdir & pin_in)));
    end
    wr(A_DIR, 8'h00);

    // R6 R7 R8 R10 random sense configurations
    for (int it = 0; it < 60; it++) begin
      old = 8'($urandom);
      nw  = (it < 4) ? ~old : 8'($urandom);
      sen = 8'($urandom) & 8'($urandom);
      bo  = 8'($urandom);
      po  = 8'($urandom);
      ie  = 8'($urandom);
      pin_in = old;
      wr(A_SENSE, sen);
      wr(A_BOTH, bo);
      wr(A_POL, po);
      wr(A_IE, ie);
      repeat (4) @(negedge clk);
      wr(A_CLR, 8'hFF);
      pin_in = nw;
      repeat (3) @(negedge clk);
      e = exp_ris(old, nw, sen, bo, po);
      peek(A_RIS, d);   chk("R7 R8 raw status", d, e);
      peek(A_MIS, d);   chk("R10 masked status", d, e & ie);
      chk("R10 irq_out", {7'd0, irq_out}, {7'd0, |(e & ie)});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule